// File: doc/BRIEF.md
# Bit-Slice Data Router

This block moves single bits from a bank of sixteen source words to a bank of sixteen destination words over one shared bus bit. The sources are split into a low group and a high group of eight. Each group has a one-of-eight selector driven by the low three bits of the source select. The top bit of the source select enables one group and disables the other, so only one source ever drives the bus. The bit each source presents to its selector is its most significant bit.

A four-bit destination address sits in a small latch. While the address strobe is high the latch is transparent, and it holds its value when the strobe drops. When the transfer strobe is high, the addressed destination shifts left by one and takes the bus bit into bit 0. Every other destination keeps its value.

The source bank loads in parallel or shifts left as a whole. Source selection can therefore cycle through all sixteen sources between two shifts. With that sequencing, the most significant bit of every source can be gathered into one destination, then the next bit into the next destination, and so on. This transposes a block of sixteen words.

Top module: `bitslice_router`

## Requirements
- R1: An active-low asynchronous reset clears all source words, all destination words and the latched destination address (address 0).
- R2: When load_en is high at a clock edge, source word s takes load_data bits [s*W +: W]. load_en has priority over shift_en.
- R3: When shift_en is high and load_en is low, every source word shifts left by one with a 0 entering bit 0. The bit a source presents to the bus is its bit W-1.
- R4: bus_bit equals the top bit of source number src_sel[2:0] + 8*src_sel[3]. A value of 0 in src_sel[3] enables the low group (sources 0 to 7) and disables the high group. A value of 1 enables the high group (sources 8 to 15) and disables the low group.
- R5: While addr_strobe is high, the effective destination address is dst_sel, and it is captured at the clock edge. While addr_strobe is low, the captured address is used and dst_sel has no effect.
- R6: When xfer is high at a clock edge, the destination word at the effective address becomes {old[W-2:0], bus_bit}. All other destination words hold.
- R7: When xfer is low, no destination word changes.
- R8: When xfer and shift_en are high in the same cycle, the transferred bit is the source's top bit from before that shift.
- R9: The transposition sequence works as follows. Load the sources. For each destination k, transfer sources 0 to 15 in order, and shift the sources on the last transfer. After this, bit W-1-s of destination k equals bit W-1-k of the loaded source s. Destination word k appears on dst_data bits [k*W +: W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Parallel load of all source words |
| load_data | input | NSRC*W | Source words, word s at [s*W +: W] |
| shift_en | input | 1 | Shift all source words left by one |
| src_sel | input | SEL_W+1 | Source select: top bit picks the group, low bits pick the source within it |
| addr_strobe | input | 1 | Destination address latch strobe (transparent while high) |
| dst_sel | input | DA_W | Destination address |
| xfer | input | 1 | Transfer the bus bit into the addressed destination |
| bus_bit | output | 1 | Shared bus bit |
| dst_data | output | NDST*W | Destination words, word k at [k*W +: W] |

## Verification
The bench builds the block with its default values: W=16, eight sources per group and sixteen destinations. With these values one full pass of sixteen transfers replaces a whole destination word, so a complete sixteen-word transposition can be checked bit by bit. Both groups and every selector code are reached. The transfer that coincides with a source shift is exercised, and so are transfers that rely only on the held address.

// File: rtl/rtr_pkg.sv
`timescale 1ns/1ps
package rtr_pkg;

    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_SHIFT = 2'd1,
        SRC_LOAD  = 2'd2
    } src_op_e;

    // Parallel load wins over shift (R2)
    function automatic src_op_e src_op(input logic load, input logic shift);
        if (load)
            return SRC_LOAD;
        else if (shift)
            return SRC_SHIFT;
        return SRC_HOLD;
    endfunction

endpackage

// File: rtl/rtr_src_bank.sv
`timescale 1ns/1ps
module rtr_src_bank
    import rtr_pkg::*;
#(
    parameter int W = 16,
    parameter int N = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_en,
    input  logic           shift_en,
    input  logic [N*W-1:0] load_data,
    output logic [N-1:0]   msb_taps
);
    typedef struct packed {
        logic [N-1:0][W-1:0] word;
    } src_state_t;

    src_state_t st_d, st_q;
    src_op_e    op;

    always_comb begin
        op   = src_op(load_en, shift_en);
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            case (op)
                SRC_LOAD:  st_d.word[i] = load_data[i*W +: W];
                SRC_SHIFT: st_d.word[i] = {st_q.word[i][W-2:0], 1'b0};
                default:   st_d.word[i] = st_q.word[i];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < N; i++)
            msb_taps[i] = st_q.word[i][W-1];
    end
endmodule

// File: rtl/rtr_half_sel.sv
`timescale 1ns/1ps
module rtr_half_sel #(
    parameter int HALF  = 8,
    parameter int SEL_W = 3
) (
    input  logic [HALF-1:0]  taps,
    input  logic [SEL_W-1:0] code,
    input  logic             enable,
    output logic             drive
);
    // A disabled group drives 0, so groups combine by OR on the bus
    always_comb begin
        drive = 1'b0;
        for (int i = 0; i < HALF; i++)
            if (enable && (code == SEL_W'(i)))
                drive = taps[i];
    end
endmodule

// File: rtl/rtr_dst_addr.sv
`timescale 1ns/1ps
module rtr_dst_addr #(
    parameter int NDST = 16,
    parameter int DA_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe,
    input  logic [DA_W-1:0] dst_sel,
    input  logic            xfer,
    output logic [NDST-1:0] grant
);
    typedef struct packed {
        logic [DA_W-1:0] addr;
    } addr_state_t;

    addr_state_t     st_d, st_q;
    logic [DA_W-1:0] eff_addr;

    always_comb begin
        st_d     = st_q;
        eff_addr = st_q.addr;
        if (strobe) begin
            st_d.addr = dst_sel;
            eff_addr  = dst_sel;
        end
        grant = '0;
        for (int k = 0; k < NDST; k++)
            if (xfer && (eff_addr == DA_W'(k)))
                grant[k] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/rtr_dst_bank.sv
`timescale 1ns/1ps
module rtr_dst_bank #(
    parameter int W    = 16,
    parameter int NDST = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NDST-1:0]   grant,
    input  logic              bus_bit,
    output logic [NDST*W-1:0] dst_data
);
    typedef struct packed {
        logic [NDST-1:0][W-1:0] word;
    } dst_state_t;

    dst_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NDST; k++)
            if (grant[k])
                st_d.word[k] = {st_q.word[k][W-2:0], bus_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        for (int k = 0; k < NDST; k++)
            dst_data[k*W +: W] = st_q.word[k];
    end
endmodule

// File: rtl/bitslice_router.sv
`timescale 1ns/1ps
module bitslice_router #(
    parameter int W     = 16,
    parameter int HALF  = 8,
    parameter int NDST  = 16,
    localparam int NSRC  = 2 * HALF,
    localparam int SEL_W = $clog2(HALF),
    localparam int DA_W  = $clog2(NDST)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [NSRC*W-1:0] load_data,
    input  logic              shift_en,
    input  logic [SEL_W:0]    src_sel,
    input  logic              addr_strobe,
    input  logic [DA_W-1:0]   dst_sel,
    input  logic              xfer,
    output logic              bus_bit,
    output logic [NDST*W-1:0] dst_data
);
    logic [NSRC-1:0] src_taps;
    logic [1:0]      half_drv;
    logic [NDST-1:0] grant;

    rtr_src_bank #(.W(W), .N(NSRC)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .shift_en  (shift_en),
        .load_data (load_data),
        .msb_taps  (src_taps)
    );

    // Two group selectors; the top select bit enables exactly one of them
    for (genvar g = 0; g < 2; g++) begin : g_half
        rtr_half_sel #(.HALF(HALF), .SEL_W(SEL_W)) u_sel (
            .taps   (src_taps[g*HALF +: HALF]),
            .code   (src_sel[SEL_W-1:0]),
            .enable (src_sel[SEL_W] == 1'(g)),
            .drive  (half_drv[g])
        );
    end

    always_comb bus_bit = |half_drv;

    rtr_dst_addr #(.NDST(NDST), .DA_W(DA_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (addr_strobe),
        .dst_sel (dst_sel),
        .xfer    (xfer),
        .grant   (grant)
    );

    rtr_dst_bank #(.W(W), .NDST(NDST)) u_dst (
        .clk      (clk),
        .rst_n    (rst_n),
        .grant    (grant),
        .bus_bit  (bus_bit),
        .dst_data (dst_data)
    );
endmodule

// File: rtl/bitslice_router_chk.sv
`timescale 1ns/1ps
module bitslice_router_chk #(
    parameter int W    = 16,
    parameter int NDST = 16,
    parameter int DA_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_strobe,
    input logic [DA_W-1:0]   dst_sel,
    input logic              xfer,
    input logic              bus_bit,
    input logic [NDST*W-1:0] dst_data
);
    logic [DA_W-1:0] lat_q, tgt_q, tgt_now;
    logic            go_q, bit_q;
    logic [W-1:0]    old_q;

    assign tgt_now = addr_strobe ? dst_sel : lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
            tgt_q <= '0;
            go_q  <= 1'b0;
            bit_q <= 1'b0;
            old_q <= '0;
        end else begin
            lat_q <= tgt_now;
            tgt_q <= tgt_now;
            go_q  <= xfer && (int'(tgt_now) < NDST);
            bit_q <= bus_bit;
            old_q <= dst_data[int'(tgt_now)*W +: W];
        end
    end

    // R6
    xfer_bit_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_q |-> dst_data[int'(tgt_q)*W] == bit_q);

    // R6
    xfer_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_q |-> dst_data[int'(tgt_q)*W+1 +: W-1] == old_q[W-2:0]);

    // R7
    xfer_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(dst_data));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> dst_data == '0);

    // R4
    bus_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(bus_bit));
endmodule

bind bitslice_router bitslice_router_chk #(.W(W), .NDST(NDST), .DA_W(DA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_strobe (addr_strobe),
    .dst_sel     (dst_sel),
    .xfer        (xfer),
    .bus_bit     (bus_bit),
    .dst_data    (dst_data)
);

// File: tb/bitslice_router_test.sv
`timescale 1ns/1ps
module bitslice_router_test;
    localparam int W = 16, NSRC = 16, NDST = 16;

    logic              clk = 1'b0, rst_n = 1'b0;
    logic              load_en = 0, shift_en = 0, addr_strobe = 0, xfer = 0;
    logic [NSRC*W-1:0] load_data = '0;
    logic [3:0]        src_sel = '0, dst_sel = '0;
    logic              bus_bit;
    logic [NDST*W-1:0] dst_data;

    int compared = 0, mismatched = 0;

    always #5 clk = ~clk;

    bitslice_router uut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
        .shift_en(shift_en), .src_sel(src_sel), .addr_strobe(addr_strobe),
        .dst_sel(dst_sel), .xfer(xfer), .bus_bit(bus_bit), .dst_data(dst_data)
    );

    // Behavioural reference model
    logic [W-1:0] src_m [NSRC];
    logic [W-1:0] dst_m [NDST];
    int           addr_m;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) src_m[i] = '0;
            for (int k = 0; k < NDST; k++) dst_m[k] = '0;
            addr_m = 0;
        end else begin
            int  eff;
            logic b;
            b   = src_m[src_sel][W-1];
            eff = addr_strobe ? int'(dst_sel) : addr_m;
            if (addr_strobe) addr_m = int'(dst_sel);
            if (xfer) dst_m[eff] = {dst_m[eff][W-2:0], b};
            if (load_en)
                for (int i = 0; i < NSRC; i++) src_m[i] = load_data[i*W +: W];
            else if (shift_en)
                for (int i = 0; i < NSRC; i++) src_m[i] = {src_m[i][W-2:0], 1'b0};
        end
    end

    // Every-clock comparison against the model (R4, R6, R7)
    always @(negedge clk) begin
        if (rst_n) begin
            compared++;
            if (bus_bit !== src_m[src_sel][W-1]) begin
                mismatched++;
                $display("FAIL R4 bus_bit got %0b expected %0b", bus_bit, src_m[src_sel][W-1]);
            end
            for (int k = 0; k < NDST; k++) begin
                if (dst_data[k*W +: W] !== dst_m[k]) begin
                    mismatched++;
                    $display("FAIL R6/R7 dst %0d got %h expected %h", k, dst_data[k*W +: W], dst_m[k]);
                end
            end
        end
    end

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input logic ld, input logic sh, input logic [3:0] ss,
                         input logic st, input logic [3:0] ds, input logic x);
        @(negedge clk);
        #1;
        load_en = ld; shift_en = sh; src_sel = ss;
        addr_strobe = st; dst_sel = ds; xfer = x;
    endtask

    function automatic logic [W-1:0] dword(input int k);
        return dst_data[k*W +: W];
    endfunction

    logic [W-1:0] wa [NSRC];
    logic [W-1:0] wb [NSRC];

    initial begin
        #2_000_000;
        compared++;
        mismatched++;
        $display("FAIL R9 watchdog got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        for (int k = 0; k < NDST; k++) check("R1 reset dst", dword(k), '0);
        check("R1 reset bus", {15'd0, bus_bit}, '0);
        #1 rst_n = 1'b1;

        // R2: load, then probe every source through both groups (R4)
        for (int s = 0; s < NSRC; s++) begin
            wa[s] = W'($urandom);
            load_data[s*W +: W] = wa[s];
        end
        drive(1, 0, 0, 0, 0, 0);
        for (int s = 0; s < NSRC; s++) begin
            drive(0, 0, 4'(s), 0, 0, 0);
            @(negedge clk);
            check("R2/R4 source top bit", {15'd0, bus_bit}, {15'd0, wa[s][W-1]});
        end

        // R2 priority: load and shift together
        for (int s = 0; s < NSRC; s++) begin
            wb[s] = W'($urandom);
            load_data[s*W +: W] = wb[s];
        end
        drive(1, 1, 3, 0, 0, 0);
        drive(0, 0, 11, 0, 0, 0);
        @(negedge clk);
        check("R2 load over shift", {15'd0, bus_bit}, {15'd0, wb[11][W-1]});

        // R3: shift presents the next bit
        drive(0, 1, 11, 0, 0, 0);
        drive(0, 0, 11, 0, 0, 0);
        @(negedge clk);
        check("R3 shift", {15'd0, bus_bit}, {15'd0, wb[11][W-2]});

        // R5: strobed address, then held address while dst_sel moves
        drive(0, 0, 0, 1, 5, 1);
        drive(0, 0, 8, 0, 9, 1);
        drive(0, 0, 1, 1, 5, 0);
        @(negedge clk);
        check("R5/R6 held address dst5", dword(5),
              {14'd0, wb[0][W-2], wb[8][W-2]});
        check("R5 dst_sel ignored dst9", dword(9), '0);

        // R7: strobe without transfer leaves destination untouched
        drive(0, 0, 2, 1, 9, 0);
        drive(0, 0, 2, 0, 9, 0);
        @(negedge clk);
        check("R7 no xfer dst9", dword(9), '0);
        check("R7 no xfer dst5", dword(5), {14'd0, wb[0][W-2], wb[8][W-2]});

        // R9 transposition with R8 shift on the last transfer of each pass
        drive(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1 rst_n = 1'b1;
        for (int s = 0; s < NSRC; s++) begin
            wa[s] = W'($urandom);
            load_data[s*W +: W] = wa[s];
        end
        drive(1, 0, 0, 0, 0, 0);
        for (int k = 0; k < NDST; k++)
            for (int s = 0; s < NSRC; s++)
                drive(0, (s == NSRC-1), 4'(s), (s == 0), 4'(k), 1);
        drive(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        for (int k = 0; k < NDST; k++) begin
            logic [W-1:0] exp;
            for (int s = 0; s < NSRC; s++) exp[W-1-s] = wa[s][W-1-k];
            check("R9 transposed word", dword(k), exp);
            check("R8 pre-shift bit", {15'd0, dword(k)[0]}, {15'd0, wa[NSRC-1][W-1-k]});
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule